// File: doc/BRIEF.md
# Vector Chaining Issue Controller

This block decides, cycle by cycle, whether the vector instruction at the head of the issue stream may start. Every vector operation streams one element per clock through a pipelined functional unit whose latency is known at issue. The operation writes its destination register element by element, starting a fixed number of cycles after issue. A later instruction that reads that register can attach to the stream only in the single cycle when the first result element arrives; this is the chain slot. An instruction that shows up earlier waits for that cycle. One that shows up later waits until the producing operation has written every element.

The controller keeps a small tracker for each vector register and each functional unit. A register tracker counts down to the chain slot and then counts the elements still to be written. A unit tracker counts the cycles during which the unit is still accepting operands. The controller presents one request per cycle. It either accepts the request through `issue` or holds it through `stall`. Because the stream is in order, a held request also holds everything behind it.

Top module: `vchain_issue_ctrl`

## Requirements
- R1: In any cycle at most one of `issue` and `stall` is high. Exactly one is high while `req_valid` is high, and both are low while `req_valid` is low.
- R2: A request whose used sources and destination are all idle, and whose unit is free, issues in the same cycle it is presented.
- R3: A producer issued in cycle c with latency L and length N keeps its destination busy from cycle c+1 through cycle c+L+N-1. The register is idle from cycle c+L+N onward. Length is 1..64, and a length of 0 is treated as 1.
- R4: For a producer with fixed latency, `vreg_chain` for its destination is high in cycle c+L only. Latency is 1..15, and a latency of 0 is treated as 1.
- R5: A request that reads a busy register and arrives at or before that register's chain slot stalls until the slot, then issues in the slot cycle.
- R6: A request that reads a busy register and arrives after its chain slot stalls until cycle c+L+N.
- R7: A producer issued with `req_lat_fixed`=0 offers no chain slot. Its readers always wait until cycle c+L+N.
- R8: `req_src_b` is ignored when `req_use_b` is 0.
- R9: A request whose destination equals one of its sources is a reader of that register. It may issue in the register's chain slot even though its destination is busy.
- R10: A request whose destination is busy and is not among its sources waits until the register is idle.
- R11: A unit (`req_fu`) issued in cycle c with length N takes no new request before cycle c+N. A chain slot that passes while a reader waits for its unit is lost, and the reader then waits until cycle c+L+N.
- R12: During and immediately after reset, `vreg_busy`, `vreg_chain` and `stall` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | An instruction is presented |
| req_src_a | input | VR_AW | First source register |
| req_src_b | input | VR_AW | Second source register |
| req_use_b | input | 1 | Second source is read |
| req_dst | input | VR_AW | Destination register |
| req_fu | input | FU_AW | Functional unit index |
| req_lat | input | LAT_W | Unit latency in cycles |
| req_lat_fixed | input | 1 | Latency is exact, so chaining is allowed |
| req_len | input | LEN_W | Vector length in elements |
| issue | output | 1 | Request accepted this cycle |
| stall | output | 1 | Request held this cycle |
| vreg_busy | output | NUM_VREG | Register still being written |
| vreg_chain | output | NUM_VREG | Register is in its chain slot this cycle |

## Verification
`issue` and `stall` are combinational from the registered trackers, so they are due in the same cycle as the request they answer. `vreg_busy` rises one cycle after issue. `vreg_chain` is due exactly L cycles after the issue cycle, and busy falls at L+N cycles. The bench numbers cycles from the producer's issue cycle as cycle 0. It drives inputs just after a rising edge and samples at the following falling edge. It compares the cycle in which the reader issues with a value worked out by hand from these counts for each table row.

// File: rtl/vchain_pkg.sv
package vchain_pkg;
  localparam int unsigned DEF_NUM_VREG = 8;
  localparam int unsigned DEF_NUM_FU   = 2;
  localparam int unsigned DEF_LAT_W    = 4;
  localparam int unsigned DEF_LEN_W    = 7;

  // why a request is being held
  typedef enum logic [1:0] {
    HZ_NONE = 2'd0,
    HZ_SRC  = 2'd1,
    HZ_DST  = 2'd2,
    HZ_UNIT = 2'd3
  } hold_e;
endpackage

// File: rtl/vc_reset_sync.sv
module vc_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign rst_n_sync = s1_q;
endmodule

// File: rtl/vc_reg_track.sv
module vc_reg_track #(
  parameter int unsigned LAT_W = 4,
  parameter int unsigned LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LAT_W-1:0] load_lat,
  input  logic [LEN_W-1:0] load_len,
  input  logic             load_fixed,
  output logic             busy,
  output logic             chain_slot
);
  logic             busy_q, busy_d;
  logic             fixed_q, fixed_d;
  logic [LAT_W-1:0] slot_q, slot_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             en;
  logic             writing;

  // first result returns when the countdown reaches one
  assign writing    = busy_q && (slot_q <= LAT_W'(1));
  assign chain_slot = busy_q && fixed_q && (slot_q == LAT_W'(1));
  assign busy       = busy_q;
  assign en         = load | busy_q;

  always_comb begin
    busy_d  = busy_q;
    fixed_d = fixed_q;
    slot_d  = slot_q;
    rem_d   = rem_q;
    if (load) begin
      busy_d  = 1'b1;
      fixed_d = load_fixed;
      slot_d  = (load_lat == '0) ? LAT_W'(1) : load_lat;
      rem_d   = (load_len == '0) ? LEN_W'(1) : load_len;
    end else if (writing) begin
      slot_d = '0;
      rem_d  = rem_q - LEN_W'(1);
      if (rem_q == LEN_W'(1)) busy_d = 1'b0;
    end else if (busy_q) begin
      slot_d = slot_q - LAT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      fixed_q <= 1'b0;
      slot_q  <= '0;
      rem_q   <= '0;
    end else if (en) begin
      busy_q  <= busy_d;
      fixed_q <= fixed_d;
      slot_q  <= slot_d;
      rem_q   <= rem_d;
    end
  end
endmodule

// File: rtl/vc_unit_track.sv
module vc_unit_track #(
  parameter int unsigned LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  output logic             busy
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             en;

  assign busy = (cnt_q != '0);
  assign en   = load | busy;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      // operands enter for len cycles, the issue cycle being the first
      cnt_d = (load_len == '0) ? '0 : load_len - LEN_W'(1);
    end else if (busy) begin
      cnt_d = cnt_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/vc_hazard.sv
module vc_hazard
  import vchain_pkg::*;
#(
  parameter int unsigned NUM_VREG = 8,
  parameter int unsigned NUM_FU   = 2,
  parameter int unsigned VR_AW    = 3,
  parameter int unsigned FU_AW    = 1
) (
  input  logic [VR_AW-1:0]    src_a,
  input  logic [VR_AW-1:0]    src_b,
  input  logic                use_b,
  input  logic [VR_AW-1:0]    dst,
  input  logic [FU_AW-1:0]    fu,
  input  logic [NUM_VREG-1:0] vbusy,
  input  logic [NUM_VREG-1:0] vchain,
  input  logic [NUM_FU-1:0]   ubusy,
  output hold_e               cause
);
  logic hold_a, hold_b, hold_d, hold_u, dst_is_src;

  always_comb begin
    dst_is_src = (dst == src_a) || (use_b && (dst == src_b));
    hold_a     = vbusy[src_a] && !vchain[src_a];
    hold_b     = use_b && vbusy[src_b] && !vchain[src_b];
    // overwriting a busy register is only allowed as a self-chain in its slot
    hold_d     = vbusy[dst] && !(vchain[dst] && dst_is_src);
    hold_u     = ubusy[fu];
    if (hold_u)                cause = HZ_UNIT;
    else if (hold_a || hold_b) cause = HZ_SRC;
    else if (hold_d)           cause = HZ_DST;
    else                       cause = HZ_NONE;
  end
endmodule

// File: rtl/vchain_issue_ctrl.sv
module vchain_issue_ctrl
  import vchain_pkg::*;
#(
  parameter int unsigned NUM_VREG = DEF_NUM_VREG,
  parameter int unsigned NUM_FU   = DEF_NUM_FU,
  parameter int unsigned LAT_W    = DEF_LAT_W,
  parameter int unsigned LEN_W    = DEF_LEN_W,
  localparam int unsigned VR_AW   = (NUM_VREG > 1) ? $clog2(NUM_VREG) : 1,
  localparam int unsigned FU_AW   = (NUM_FU > 1) ? $clog2(NUM_FU) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [VR_AW-1:0]    req_src_a,
  input  logic [VR_AW-1:0]    req_src_b,
  input  logic                req_use_b,
  input  logic [VR_AW-1:0]    req_dst,
  input  logic [FU_AW-1:0]    req_fu,
  input  logic [LAT_W-1:0]    req_lat,
  input  logic                req_lat_fixed,
  input  logic [LEN_W-1:0]    req_len,
  output logic                issue,
  output logic                stall,
  output logic [NUM_VREG-1:0] vreg_busy,
  output logic [NUM_VREG-1:0] vreg_chain
);
  logic                rst_n_i;
  logic [NUM_FU-1:0]   unit_busy;
  hold_e               cause;

  vc_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  vc_hazard #(
    .NUM_VREG (NUM_VREG),
    .NUM_FU   (NUM_FU),
    .VR_AW    (VR_AW),
    .FU_AW    (FU_AW)
  ) u_haz (
    .src_a  (req_src_a),
    .src_b  (req_src_b),
    .use_b  (req_use_b),
    .dst    (req_dst),
    .fu     (req_fu),
    .vbusy  (vreg_busy),
    .vchain (vreg_chain),
    .ubusy  (unit_busy),
    .cause  (cause)
  );

  assign stall = req_valid && (cause != HZ_NONE);
  assign issue = req_valid && (cause == HZ_NONE);

  for (genvar gi = 0; gi < NUM_VREG; gi++) begin : g_vreg
    logic ld;
    assign ld = issue && (req_dst == VR_AW'(gi));
    vc_reg_track #(
      .LAT_W (LAT_W),
      .LEN_W (LEN_W)
    ) u_trk (
      .clk        (clk),
      .rst_n      (rst_n_i),
      .load       (ld),
      .load_lat   (req_lat),
      .load_len   (req_len),
      .load_fixed (req_lat_fixed),
      .busy       (vreg_busy[gi]),
      .chain_slot (vreg_chain[gi])
    );
  end

  for (genvar gu = 0; gu < NUM_FU; gu++) begin : g_unit
    logic ld;
    assign ld = issue && (req_fu == FU_AW'(gu));
    vc_unit_track #(
      .LEN_W (LEN_W)
    ) u_ut (
      .clk      (clk),
      .rst_n    (rst_n_i),
      .load     (ld),
      .load_len (req_len),
      .busy     (unit_busy[gu])
    );
  end
endmodule

// File: rtl/vc_checker.sv
module vc_checker #(
  parameter int unsigned NUM_VREG = 8,
  parameter int unsigned VR_AW    = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [VR_AW-1:0]    req_src_a,
  input logic [VR_AW-1:0]    req_src_b,
  input logic                req_use_b,
  input logic [VR_AW-1:0]    req_dst,
  input logic                issue,
  input logic                stall,
  input logic [NUM_VREG-1:0] vreg_busy,
  input logic [NUM_VREG-1:0] vreg_chain
);
  // R1: a presented request is either taken or held, never both
  a_r1_issue_xor_stall: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (issue != stall));
  // R1: nothing happens without a request
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!issue && !stall));
  // R3: destination is busy right after issue
  a_r3_busy_next: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> vreg_busy[$past(req_dst)]);
  // R4: a chain slot belongs to a register still being written
  a_r4_slot_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (vreg_chain & ~vreg_busy) == '0);
  // R5: a busy first source is read only in its chain slot
  a_r5_src_a_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && vreg_busy[req_src_a]) |-> vreg_chain[req_src_a]);
  // R6: same for a used second source
  a_r6_src_b_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && req_use_b && vreg_busy[req_src_b]) |-> vreg_chain[req_src_b]);
endmodule

bind vchain_issue_ctrl vc_checker #(
  .NUM_VREG (NUM_VREG),
  .VR_AW    (VR_AW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_src_a  (req_src_a),
  .req_src_b  (req_src_b),
  .req_use_b  (req_use_b),
  .req_dst    (req_dst),
  .issue      (issue),
  .stall      (stall),
  .vreg_busy  (vreg_busy),
  .vreg_chain (vreg_chain)
);

// File: tb/sim_vchain_issue_ctrl.sv
`timescale 1ns/1ps
module sim_vchain_issue_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_src_a = '0, req_src_b = '0, req_dst = '0;
  logic       req_use_b = 1'b0;
  logic [0:0] req_fu = '0;
  logic [3:0] req_lat = '0;
  logic       req_lat_fixed = 1'b0;
  logic [6:0] req_len = '0;
  logic       issue, stall;
  logic [7:0] vreg_busy, vreg_chain;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vchain_issue_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_src_a(req_src_a), .req_src_b(req_src_b), .req_use_b(req_use_b),
    .req_dst(req_dst), .req_fu(req_fu), .req_lat(req_lat),
    .req_lat_fixed(req_lat_fixed), .req_len(req_len),
    .issue(issue), .stall(stall), .vreg_busy(vreg_busy), .vreg_chain(vreg_chain)
  );

  // kind: 0 independent, 1 reads producer dst, 2 self-loop on one register, 3 writes producer dst
  typedef struct packed {
    int lat; int len; bit fixed; int kind; bit same_fu; int d; int exp; int rq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{4, 8, 1'b1, 1, 1'b0, 2, 4, 5},    // R5 early
    '{4, 8, 1'b1, 1, 1'b0, 4, 4, 5},    // R5 exactly in slot
    '{4, 8, 1'b1, 1, 1'b0, 5, 12, 6},   // R6 just missed
    '{4, 8, 1'b1, 1, 1'b0, 12, 12, 6},  // R6 at completion
    '{4, 8, 1'b1, 1, 1'b0, 14, 14, 6},  // R6 after completion
    '{6, 3, 1'b1, 1, 1'b0, 1, 6, 5},    // R5 long wait
    '{3, 5, 1'b0, 1, 1'b0, 3, 8, 7},    // R7 in would-be slot
    '{3, 2, 1'b0, 1, 1'b0, 1, 5, 7},    // R7 early
    '{3, 10, 1'b1, 1, 1'b1, 1, 13, 11}, // R11 slot lost to unit
    '{5, 8, 1'b1, 0, 1'b0, 1, 1, 2},    // R2 independent
    '{5, 8, 1'b1, 0, 1'b1, 2, 8, 11},   // R11 unit reuse
    '{2, 6, 1'b1, 2, 1'b0, 1, 2, 9},    // R9 self-loop
    '{2, 4, 1'b1, 3, 1'b0, 1, 6, 10},   // R10 overwrite
    '{1, 1, 1'b1, 1, 1'b0, 1, 1, 4}     // R4 shortest
  };

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    req_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic present(input int a, input int b, input bit ub, input int dst,
                         input int fu, input int lat, input int len, input bit fx);
    req_src_a = 3'(a); req_src_b = 3'(b); req_use_b = ub; req_dst = 3'(dst);
    req_fu = 1'(fu); req_lat = 4'(lat); req_len = 7'(len); req_lat_fixed = fx;
    req_valid = 1'b1;
  endtask

  task automatic run_vec(input int idx);
    vec_t v;
    int cyc, got, preg;
    v = TBL[idx];
    preg = (v.kind == 2) ? 2 : 3;
    do_reset();
    if (v.kind == 2) present(2, 1, 1'b0, 2, 0, v.lat, v.len, v.fixed);
    else             present(0, 1, 1'b1, 3, 0, v.lat, v.len, v.fixed);
    @(negedge clk);
    check(issue === 1'b1, "R2 producer", int'(issue), 1);
    @(posedge clk); #1;
    req_valid = 1'b0;
    cyc = 1;
    while (cyc < v.d) begin @(posedge clk); #1; cyc++; end
    case (v.kind)
      0: present(4, 5, 1'b1, 6, v.same_fu ? 0 : 1, 2, 4, 1'b1);
      1: if (idx % 2 == 0) present(3, 5, 1'b1, 6, v.same_fu ? 0 : 1, 2, 4, 1'b1);
         else              present(5, 3, 1'b1, 6, v.same_fu ? 0 : 1, 2, 4, 1'b1);
      2: present(preg, 1, 1'b0, preg, 1, 2, 4, 1'b1);
      default: present(4, 5, 1'b0, 3, 1, 2, 4, 1'b1);
    endcase
    got = -1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (cyc == v.d && v.exp > v.d)
        check(stall === 1'b1 && issue === 1'b0, "R1 held", int'(stall), 1);
      if (issue === 1'b1) begin got = cyc; break; end
      @(posedge clk); #1;
      cyc++;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    check(got == v.exp, $sformatf("R%0d row %0d issue cycle", v.rq, idx), got, v.exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R12: reset state
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(vreg_busy === 8'h00 && vreg_chain === 8'h00 && stall === 1'b0,
          "R12 in reset", int'(vreg_busy), 0);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(vreg_busy === 8'h00 && vreg_chain === 8'h00 && stall === 1'b0,
          "R12 after reset", int'(vreg_busy), 0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R3 and R4: busy and chain-slot timing for L=5, N=3 on register 4
    do_reset();
    present(0, 1, 1'b0, 4, 1, 5, 3, 1'b1);
    @(posedge clk); #1;
    req_valid = 1'b0;
    for (int c = 1; c <= 9; c++) begin
      @(negedge clk);
      check(vreg_chain[4] === (c == 5), $sformatf("R4 chain at cycle %0d", c),
            int'(vreg_chain[4]), int'(c == 5));
      check(vreg_busy[4] === (c < 8), $sformatf("R3 busy at cycle %0d", c),
            int'(vreg_busy[4]), int'(c < 8));
      @(posedge clk); #1;
    end

    // R3/R4: zero latency and zero length behave as one
    do_reset();
    present(0, 1, 1'b0, 7, 0, 0, 0, 1'b1);
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    check(vreg_chain[7] === 1'b1, "R4 zero latency slot at cycle 1", int'(vreg_chain[7]), 1);
    @(posedge clk); #1;
    @(negedge clk);
    check(vreg_busy[7] === 1'b0, "R3 zero length idle at cycle 2", int'(vreg_busy[7]), 0);

    // R8: busy register on an unused second source does not hold the request
    do_reset();
    present(0, 1, 1'b1, 3, 0, 4, 8, 1'b1);
    @(posedge clk); #1;
    present(5, 3, 1'b0, 6, 1, 2, 4, 1'b1);
    @(negedge clk);
    check(issue === 1'b1 && stall === 1'b0, "R8 unused src_b", int'(issue), 1);
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    check(issue === 1'b0 && stall === 1'b0, "R1 idle", int'(issue), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule